// File: doc/BRIEF.md
# Operand Addressing Byte Decoder

This block sits behind an opcode decoder in a 32-bit processor front end. It takes the bytes that describe where an instruction's operand lives. These are a mode/register/memory byte, an optional scale-index-base byte, and a displacement of zero, one or four bytes. The bytes arrive one per handshake on a valid/ready byte stream. The block works out from the mode byte whether the scale-index-base byte and a displacement follow, and how long the displacement is. It then gathers them and produces either a register-operand result or a 32-bit effective address.

Register values come from a general register file through two combinational read ports. Port A supplies the base register and port B supplies the index register. The register contents are assumed to stay stable while an operand is being decoded. When decoding ends, the block raises a one-cycle completion pulse. The pulse carries the result, an illegal-encoding flag and the number of bytes consumed. The block then waits for the next mode byte.

Top module: `modrm_addr_decoder`

## Requirements
- R1: A mode byte whose top two bits are 11 finishes decoding at once. The result is flagged as a register operand, the register number is the mode byte's low three bits, the address output is 0 and the byte count is 1.
- R2: With top bits 00 and a low field other than 100 or 101, the address is the register selected by the low field. No further byte is taken and the count is 1.
- R3: With top bits 00 and low field 101, four displacement bytes follow, least significant first. The address equals that displacement alone, and the count is 5.
- R4: With top bits 01, one displacement byte follows. It is sign-extended and added to the register named by the low field, and the count is 2 (3 with a scale-index-base byte).
- R5: With top bits 10, four displacement bytes follow, least significant first. They are added to the selected base, and the count is 5 (6 with a scale-index-base byte).
- R6: A low field of 100 in any memory mode (top bits not 11) means a scale-index-base byte follows. In that byte, bits 7:6 are the scale code, bits 5:3 the index and bits 2:0 the base. The address is base plus index shifted left by the scale code, so the multiplier is 1, 2, 4 or 8.
- R7: An index field of 100 adds no index term. It never selects register 4.
- R8: A base field of 101 in the scale-index-base byte means no base register and a four-byte displacement when the top bits are 00. It selects register 5 when the top bits are 01 or 10.
- R9: Register code n (0 to 7) reads entry n of the register file; register 4 is the stack pointer and register 5 the frame pointer.
- R10: The address is formed modulo 2^32.
- R11: Completion is a pulse one cycle wide, in the cycle after the last byte's handshake. The ready output is low during that cycle and high again afterwards. The count is between 1 and 6.
- R12: A scale-index-base byte with index field 100 and a non-zero scale code sets the illegal flag. The address is still formed without an index term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_byte | input | 8 | Byte stream data |
| in_ready | output | 1 | Decoder can take a byte |
| rf_sel_a | output | 3 | Base register read address |
| rf_data_a | input | 32 | Base register read data |
| rf_sel_b | output | 3 | Index register read address |
| rf_data_b | input | 32 | Index register read data |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Result is a register operand |
| reg_num | output | 3 | Register operand number |
| eff_addr | output | 32 | Effective address |
| illegal | output | 1 | Meaningless scale with no index |
| byte_count | output | 3 | Bytes consumed by this operand |

## Verification
Each byte is taken on the rising edge where valid and ready are both high. The result, count and flags all appear together with the completion pulse exactly one cycle after the final byte's handshake. The bench drives inputs on falling edges and samples on the falling edge that follows the final handshake, where the pulse must be high and ready low. It checks at every falling edge before that point that completion stays low, and at the next falling edge that the pulse has ended and ready has returned. Gaps with valid low are inserted between bytes to show that timing is tied to handshakes, not to cycles.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

    localparam int ADDR_W    = 32;
    localparam int NUM_REGS  = 8;
    localparam int SEL_W     = $clog2(NUM_REGS);
    localparam int LONG_DISP = ADDR_W / 8;
    localparam int CNT_W     = 3;

    localparam logic [1:0] MOD_IND  = 2'b00;
    localparam logic [1:0] MOD_D8   = 2'b01;
    localparam logic [1:0] MOD_D32  = 2'b10;
    localparam logic [1:0] MOD_REG  = 2'b11;

    localparam logic [2:0] CODE_ESC  = 3'b100;
    localparam logic [2:0] CODE_BP   = 3'b101;

    typedef enum logic [1:0] {
        ST_MODE,
        ST_SIB,
        ST_DISP,
        ST_DONE
    } dec_state_e;

    typedef struct packed {
        dec_state_e              st;
        logic [1:0]              mode;
        logic [SEL_W-1:0]        base_sel;
        logic [SEL_W-1:0]        index_sel;
        logic [1:0]              scale;
        logic                    has_base;
        logic                    has_index;
        logic [ADDR_W-1:0]       disp;
        logic [CNT_W-1:0]        disp_need;
        logic [CNT_W-1:0]        disp_got;
        logic [CNT_W-1:0]        count;
        logic                    done;
        logic                    is_reg;
        logic [SEL_W-1:0]        reg_num;
        logic [ADDR_W-1:0]       ea;
        logic                    illegal;
    } dec_regs_t;

endpackage

// File: rtl/modrm_field_decode.sv
module modrm_field_decode
    import modrm_pkg::*;
(
    input  logic [1:0]       mode_i,
    input  logic [2:0]       rm_i,
    input  logic [7:0]       sib_i,
    output logic             need_sib_o,
    output logic [CNT_W-1:0] rm_disp_len_o,
    output logic             rm_has_base_o,
    output logic             sib_has_base_o,
    output logic             sib_has_index_o,
    output logic [CNT_W-1:0] sib_disp_len_o,
    output logic             sib_bad_o
);

    logic [1:0] sib_scale;
    logic [2:0] sib_index;
    logic [2:0] sib_base;
    logic [CNT_W-1:0] mode_len;

    assign sib_scale = sib_i[7:6];
    assign sib_index = sib_i[5:3];
    assign sib_base  = sib_i[2:0];

    always_comb begin
        case (mode_i)
            MOD_D8:  mode_len = CNT_W'(1);
            MOD_D32: mode_len = CNT_W'(LONG_DISP);
            default: mode_len = '0;
        endcase
    end

    always_comb begin
        need_sib_o    = (mode_i != MOD_REG) && (rm_i == CODE_ESC);
        rm_has_base_o = !((mode_i == MOD_IND) && (rm_i == CODE_BP));
        rm_disp_len_o = rm_has_base_o ? mode_len : CNT_W'(LONG_DISP);

        sib_has_index_o = (sib_index != CODE_ESC);
        sib_bad_o       = (sib_index == CODE_ESC) && (sib_scale != 2'b00);
        sib_has_base_o  = !((mode_i == MOD_IND) && (sib_base == CODE_BP));
        sib_disp_len_o  = sib_has_base_o ? mode_len : CNT_W'(LONG_DISP);
    end

endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] base_i,
    input  logic         base_en_i,
    input  logic [W-1:0] index_i,
    input  logic         index_en_i,
    input  logic [1:0]   scale_i,
    input  logic [W-1:0] disp_i,
    output logic [W-1:0] sum_o
);

    logic [W-1:0] base_term;
    logic [W-1:0] index_term;

    always_comb begin
        base_term  = base_en_i  ? base_i : '0;
        index_term = index_en_i ? (index_i << scale_i) : '0;
        sum_o      = base_term + index_term + disp_i;
    end

endmodule

// File: rtl/modrm_addr_decoder.sv
module modrm_addr_decoder
    import modrm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic [SEL_W-1:0]  rf_sel_a,
    input  logic [ADDR_W-1:0] rf_data_a,
    output logic [SEL_W-1:0]  rf_sel_b,
    input  logic [ADDR_W-1:0] rf_data_b,
    output logic              done,
    output logic              is_reg,
    output logic [SEL_W-1:0]  reg_num,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              illegal,
    output logic [CNT_W-1:0]  byte_count
);

    dec_regs_t q, d;

    logic             take;
    logic [1:0]       cur_mode;
    logic             need_sib;
    logic [CNT_W-1:0] rm_disp_len;
    logic             rm_has_base;
    logic             sib_has_base;
    logic             sib_has_index;
    logic [CNT_W-1:0] sib_disp_len;
    logic             sib_bad;

    logic              add_base_en;
    logic              add_index_en;
    logic [1:0]        add_scale;
    logic [ADDR_W-1:0] add_disp;
    logic [ADDR_W-1:0] add_sum;
    logic [ADDR_W-1:0] disp_full;
    logic              disp_last;

    assign in_ready = (q.st != ST_DONE);
    assign take     = in_valid && in_ready;
    assign cur_mode = (q.st == ST_MODE) ? in_byte[7:6] : q.mode;

    assign rf_sel_a = ((q.st == ST_MODE) || (q.st == ST_SIB)) ? in_byte[2:0] : q.base_sel;
    assign rf_sel_b = (q.st == ST_SIB) ? in_byte[5:3] : q.index_sel;

    modrm_field_decode u_fields (
        .mode_i          (cur_mode),
        .rm_i            (in_byte[2:0]),
        .sib_i           (in_byte),
        .need_sib_o      (need_sib),
        .rm_disp_len_o   (rm_disp_len),
        .rm_has_base_o   (rm_has_base),
        .sib_has_base_o  (sib_has_base),
        .sib_has_index_o (sib_has_index),
        .sib_disp_len_o  (sib_disp_len),
        .sib_bad_o       (sib_bad)
    );

    // Displacement assembly: short form sign-extends, long form fills LSB first.
    always_comb begin
        disp_full = q.disp;
        if (q.disp_need == CNT_W'(1)) begin
            disp_full = {{(ADDR_W-8){in_byte[7]}}, in_byte};
        end else begin
            disp_full[8*q.disp_got +: 8] = in_byte;
        end
        disp_last = ((q.disp_got + CNT_W'(1)) == q.disp_need);
    end

    always_comb begin
        add_base_en  = 1'b1;
        add_index_en = 1'b0;
        add_scale    = q.scale;
        add_disp     = '0;
        case (q.st)
            ST_SIB: begin
                add_base_en  = sib_has_base;
                add_index_en = sib_has_index;
                add_scale    = in_byte[7:6];
            end
            ST_DISP: begin
                add_base_en  = q.has_base;
                add_index_en = q.has_index;
                add_disp     = disp_full;
            end
            default: ;
        endcase
    end

    ea_adder #(.W(ADDR_W)) u_adder (
        .base_i     (rf_data_a),
        .base_en_i  (add_base_en),
        .index_i    (rf_data_b),
        .index_en_i (add_index_en),
        .scale_i    (add_scale),
        .disp_i     (add_disp),
        .sum_o      (add_sum)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_MODE: begin
                if (take) begin
                    d.mode      = cur_mode;
                    d.count     = CNT_W'(1);
                    d.base_sel  = in_byte[2:0];
                    d.index_sel = '0;
                    d.has_base  = rm_has_base;
                    d.has_index = 1'b0;
                    d.scale     = 2'b00;
                    d.disp      = '0;
                    d.disp_got  = '0;
                    d.disp_need = rm_disp_len;
                    d.illegal   = 1'b0;
                    d.is_reg    = 1'b0;
                    d.reg_num   = '0;
                    if (cur_mode == MOD_REG) begin
                        d.st      = ST_DONE;
                        d.done    = 1'b1;
                        d.is_reg  = 1'b1;
                        d.reg_num = in_byte[2:0];
                        d.ea      = '0;
                    end else if (need_sib) begin
                        d.st = ST_SIB;
                    end else if (rm_disp_len != '0) begin
                        d.st = ST_DISP;
                    end else begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                        d.ea   = add_sum;
                    end
                end
            end
            ST_SIB: begin
                if (take) begin
                    d.count     = q.count + CNT_W'(1);
                    d.base_sel  = in_byte[2:0];
                    d.index_sel = in_byte[5:3];
                    d.scale     = in_byte[7:6];
                    d.has_base  = sib_has_base;
                    d.has_index = sib_has_index;
                    d.illegal   = sib_bad;
                    d.disp_need = sib_disp_len;
                    if (sib_disp_len != '0) begin
                        d.st = ST_DISP;
                    end else begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                        d.ea   = add_sum;
                    end
                end
            end
            ST_DISP: begin
                if (take) begin
                    d.count    = q.count + CNT_W'(1);
                    d.disp     = disp_full;
                    d.disp_got = q.disp_got + CNT_W'(1);
                    if (disp_last) begin
                        d.st   = ST_DONE;
                        d.done = 1'b1;
                        d.ea   = add_sum;
                    end
                end
            end
            default: begin
                d.st = ST_MODE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_MODE;
        end else begin
            q <= d;
        end
    end

    assign done       = q.done;
    assign is_reg     = q.is_reg;
    assign reg_num    = q.reg_num;
    assign eff_addr   = q.ea;
    assign illegal    = q.illegal;
    assign byte_count = q.count;

endmodule

// File: rtl/modrm_addr_decoder_chk.sv
module modrm_addr_decoder_chk
    import modrm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              done,
    input logic              is_reg,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              illegal,
    input logic [CNT_W-1:0]  byte_count
);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    assert_ready_back_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

    assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (byte_count >= CNT_W'(1)) && (byte_count <= CNT_W'(6)));

    assert_reg_operand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_reg) |-> (byte_count == CNT_W'(1)) && (eff_addr == '0));

    assert_illegal_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!is_reg && byte_count >= CNT_W'(2)));

endmodule

bind modrm_addr_decoder modrm_addr_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .done       (done),
    .is_reg     (is_reg),
    .eff_addr   (eff_addr),
    .illegal    (illegal),
    .byte_count (byte_count)
);

// File: tb/modrm_addr_decoder_test.sv
module modrm_addr_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic [2:0]  rf_sel_a, rf_sel_b;
    logic [31:0] rf_data_a, rf_data_b;
    logic        done, is_reg, illegal;
    logic [2:0]  reg_num, byte_count;
    logic [31:0] eff_addr;

    logic [31:0] regs [8];
    int checks = 0;
    int failures = 0;

    assign rf_data_a = regs[rf_sel_a];
    assign rf_data_b = regs[rf_sel_b];

    always #(CLK_PERIOD/2) clk = ~clk;

    modrm_addr_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .rf_sel_a(rf_sel_a), .rf_data_a(rf_data_a),
        .rf_sel_b(rf_sel_b), .rf_data_b(rf_data_b), .done(done),
        .is_reg(is_reg), .reg_num(reg_num), .eff_addr(eff_addr),
        .illegal(illegal), .byte_count(byte_count)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: parse the byte list and form the expected result.
    task automatic predict(input logic [7:0] b[$], output logic e_reg, output logic [2:0] e_num,
                           output logic [31:0] e_ea, output logic e_ill, output int e_cnt);
        int md, rm, pos, dlen, sc, bi, ii;
        logic use_b, use_i;
        logic [31:0] disp;
        md = int'(b[0][7:6]); rm = int'(b[0][2:0]);
        e_reg = 1'b0; e_num = 3'd0; e_ea = 32'd0; e_ill = 1'b0;
        pos = 1; dlen = 0; sc = 0; bi = rm; ii = 0; use_b = 1'b1; use_i = 1'b0; disp = 32'd0;
        if (md == 3) begin
            e_reg = 1'b1; e_num = 3'(rm); e_cnt = 1;
            return;
        end
        if (md == 1) dlen = 1;
        if (md == 2) dlen = 4;
        if (rm == 4) begin
            sc = int'(b[1][7:6]); ii = int'(b[1][5:3]); bi = int'(b[1][2:0]); pos = 2;
            use_i = (ii != 4);
            e_ill = (ii == 4) && (sc != 0);
            if (md == 0 && bi == 5) begin use_b = 1'b0; dlen = 4; end
        end else if (md == 0 && rm == 5) begin
            use_b = 1'b0; dlen = 4;
        end
        if (dlen == 1) disp = 32'($signed(b[pos]));
        if (dlen == 4) disp = {b[pos+3], b[pos+2], b[pos+1], b[pos]};
        e_ea = (use_b ? regs[bi] : 32'd0) + (use_i ? regs[ii] * (32'd1 << sc) : 32'd0) + disp;
        e_cnt = pos + dlen;
    endtask

    task automatic run_case(input string req, input logic [7:0] b[$], input int gap);
        logic e_reg, e_ill;
        logic [2:0] e_num;
        logic [31:0] e_ea;
        int e_cnt;
        predict(b, e_reg, e_num, e_ea, e_ill, e_cnt);
        foreach (b[i]) begin
            for (int g = 0; g < gap && i > 0; g++) begin
                in_valid = 1'b0;
                @(negedge clk);
                check(req, "done low during gap", 32'(done), 32'd0);
            end
            check(req, "ready before byte", 32'(in_ready), 32'd1);
            in_valid = 1'b1; in_byte = b[i];
            @(negedge clk);
            if (i < b.size() - 1) check(req, "done low mid-operand", 32'(done), 32'd0);
        end
        in_valid = 1'b0;
        check(req, "done pulse", 32'(done), 32'd1);
        check(req, "ready low at done", 32'(in_ready), 32'd0);
        check(req, "register flag", 32'(is_reg), 32'(e_reg));
        if (e_reg) check(req, "register number", 32'(reg_num), 32'(e_num));
        check(req, "address", eff_addr, e_ea);
        check(req, "illegal flag", 32'(illegal), 32'(e_ill));
        check(req, "byte count", 32'(byte_count), 32'(e_cnt));
        @(negedge clk);
        check("R11", "pulse ended", 32'(done), 32'd0);
        check("R11", "ready restored", 32'(in_ready), 32'd1);
    endtask

    initial begin
        regs[0] = 32'h0000_1000; regs[1] = 32'h0000_2000; regs[2] = 32'h0003_0000;
        regs[3] = 32'h0040_0000; regs[4] = 32'h7FFF_FF00; regs[5] = 32'h0000_8000;
        regs[6] = 32'h0000_0010; regs[7] = 32'h0000_0100;
        repeat (3) @(negedge clk);
        check("R11", "reset done", 32'(done), 32'd0);
        check("R11", "reset ready", 32'(in_ready), 32'd0 + 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        run_case("R1",  '{8'hC3}, 0);
        run_case("R1",  '{8'hFE}, 0);
        run_case("R2",  '{8'h00}, 0);
        run_case("R9",  '{8'h06}, 0);
        run_case("R3",  '{8'h05, 8'h78, 8'h56, 8'h34, 8'h12}, 0);
        run_case("R4",  '{8'h41, 8'h80}, 0);
        run_case("R4",  '{8'h45, 8'h7F}, 1);
        run_case("R5",  '{8'h82, 8'hEF, 8'hBE, 8'hAD, 8'hDE}, 2);
        run_case("R6",  '{8'h04, 8'hB3}, 0);
        run_case("R6",  '{8'h04, 8'h08}, 0);
        run_case("R6",  '{8'h04, 8'h4F}, 0);
        run_case("R7",  '{8'h04, 8'h24}, 0);
        run_case("R8",  '{8'h04, 8'hFD, 8'h01, 8'h00, 8'h10, 8'h00}, 0);
        run_case("R8",  '{8'h44, 8'h6D, 8'hF0}, 1);
        run_case("R5",  '{8'h84, 8'h08, 8'h00, 8'h00, 8'h01, 8'h00}, 0);
        run_case("R12", '{8'h04, 8'h64}, 0);
        regs[0] = 32'hFFFF_FFF0;
        run_case("R10", '{8'h80, 8'h20, 8'h00, 8'h00, 8'h00}, 0);
        regs[7] = 32'hF000_0000;
        run_case("R10", '{8'h04, 8'hF8}, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule